// File: doc/BRIEF.md
# JTAG Bitstream Configuration Sequencer

This block is a JTAG master that loads a configuration bitstream into one target device through the device's test access port. It generates TCK from the system clock and drives TMS and TDI. After a start pulse it runs a fixed script without further control. The script resets the TAP and loads the configuration-load instruction. It then shifts the whole bitstream into the data register, resets the TAP again, and loads the startup instruction. Finally it clocks the startup sequence in Run-Test/Idle and parks the TAP in Test-Logic-Reset.

Bitstream bits arrive one per transfer on a ready/valid stream, with the first bit being the most significant. A `last` flag marks the final bit, and that flag sets the bitstream length N. If no bit is offered when one is needed, TCK is held low. A free-running count of issued TCK cycles is exposed on a port, so an observer can confirm that a run took exactly 48 + STARTUP_CYC + N cycles. With the default STARTUP_CYC of 12 this is 60 + N.

Top module: `cfg_tap_loader`

## Requirements
- R1: After reset, TCK is 0, TMS is 1, TDI is 0, done is 0, s_ready is 0 and the cycle count is 0.
- R2: Every high half of TCK lasts exactly DIV_HALF system clocks, and every low half lasts at least DIV_HALF. TMS and TDI never change while TCK is high.
- R3: The run opens with TMS = 1 for five TCK cycles, then 0 for one, then 1 for two, then 0 for two. TDI is 0 in every TCK cycle that does not shift an instruction or data bit.
- R4: The configuration instruction is shifted LSB first over ten cycles. TDI carries 1,1,1,0,0,0,1,0,1 and then CFG_IR_MSB. TMS is 0 for the first nine cycles and 1 on the tenth.
- R5: After the configuration instruction, TMS is 1,1,0,0 over four cycles to reach Shift-DR.
- R6: Stream bits go out on TDI in arrival order, one per TCK cycle, with TMS 0. The exception is the bit flagged last, which goes out with TMS 1. The following cycle has TMS 1 (Update-DR).
- R7: After Update-DR, TMS is 1,1,1,1,0 (reset, ending in Run-Test/Idle), then 1,1, then 0,0.
- R8: The startup instruction is shifted LSB first. TDI carries 1,1,1,0,0,1,1,0,0 and then START_IR_MSB. TMS is 1 only on the tenth cycle and on one extra cycle after it (Update-IR).
- R9: STARTUP_CYC cycles (default 12) follow with TMS 0, then three cycles with TMS 1. After that, done is 1, TCK stays low and TMS stays 1.
- R10: When done rises, the cycle count and the number of rising TCK edges both equal 48 + STARTUP_CYC + N. Each rising edge of TCK adds exactly one to the count.
- R11: While the next data bit is awaited, s_ready is 1 and TCK stays low, and the count does not move. s_ready is 1 only in that situation.
- R12: A start pulse during a run is ignored. A start pulse while idle or done begins a new run and clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration run (ignored while busy) |
| done | output | 1 | Run finished, TAP parked in Test-Logic-Reset |
| s_valid | input | 1 | Stream bit offered |
| s_data | input | 1 | Stream bit value |
| s_last | input | 1 | Offered bit is the final bitstream bit |
| s_ready | output | 1 | Sequencer takes the offered bit this clock |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data to the target |
| tck_count | output | CNT_W | Rising TCK edges issued since the last start |

## Verification
A wrong phase or step index shows up as a TMS or TDI value that departs from the expected script. It appears at the very next rising TCK edge, so comparing every sampled edge against the script pins the fault to one cycle. A wrong exit from the data phase changes both the edge total and the final count, and both are checked when done rises. A fault in the stall handshake shows up within one system clock, either as TCK rising while s_ready is high or as the count moving during a wait.

// File: rtl/cfg_tap_pkg.sv
package cfg_tap_pkg;

    localparam int STEP_W = 16;
    localparam int IR_LEN = 10;

    // low nine instruction bits, bit 0 shifted first
    localparam logic [8:0] CFG_IR_LOW   = 9'h147;
    localparam logic [8:0] START_IR_LOW = 9'h067;

    typedef enum logic [4:0] {
        PH_IDLE,
        PH_RST_A,
        PH_RTI_A,
        PH_SEL_IR_A,
        PH_ENT_IR_A,
        PH_IR_CFG,
        PH_SEL_DR,
        PH_ENT_DR,
        PH_DATA,
        PH_UPD_DR,
        PH_RST_B,
        PH_SEL_IR_B,
        PH_ENT_IR_B,
        PH_IR_START,
        PH_UPD_IR,
        PH_STARTUP,
        PH_TO_TLR,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic tms;
        logic tdi;
    } pin_pair_t;

    function automatic logic [STEP_W-1:0] phase_len(phase_e ph, logic [STEP_W-1:0] startup);
        case (ph)
            PH_RST_A, PH_RST_B:                    return 16'd5;
            PH_RTI_A, PH_UPD_DR, PH_UPD_IR:        return 16'd1;
            PH_IR_CFG, PH_IR_START:                return 16'd10;
            PH_TO_TLR:                             return 16'd3;
            PH_STARTUP:                            return startup;
            default:                               return 16'd2;
        endcase
    endfunction

    function automatic phase_e next_phase(phase_e ph);
        case (ph)
            PH_RST_A:    return PH_RTI_A;
            PH_RTI_A:    return PH_SEL_IR_A;
            PH_SEL_IR_A: return PH_ENT_IR_A;
            PH_ENT_IR_A: return PH_IR_CFG;
            PH_IR_CFG:   return PH_SEL_DR;
            PH_SEL_DR:   return PH_ENT_DR;
            PH_ENT_DR:   return PH_DATA;
            PH_DATA:     return PH_UPD_DR;
            PH_UPD_DR:   return PH_RST_B;
            PH_RST_B:    return PH_SEL_IR_B;
            PH_SEL_IR_B: return PH_ENT_IR_B;
            PH_ENT_IR_B: return PH_IR_START;
            PH_IR_START: return PH_UPD_IR;
            PH_UPD_IR:   return PH_STARTUP;
            PH_STARTUP:  return PH_TO_TLR;
            default:     return PH_DONE;
        endcase
    endfunction

    function automatic logic ir_pick(logic [IR_LEN-1:0] ir, logic [STEP_W-1:0] pos);
        logic b;
        b = 1'b0;
        for (int k = 0; k < IR_LEN; k++) begin
            if (pos == STEP_W'(k)) b = ir[k];
        end
        return b;
    endfunction

endpackage

// File: rtl/tap_tck_div.sv
module tap_tck_div #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tck,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic          tck_q;
    logic [CW-1:0] cnt_q;
    logic          term;

    always_comb begin
        term    = (cnt_q == LAST);
        rise_ev = !tck_q && en && term;
        fall_ev = tck_q && term;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tck_q <= 1'b0;
            cnt_q <= '0;
        end else if (!tck_q && !en) begin
            cnt_q <= '0;
        end else if (term) begin
            cnt_q <= '0;
            tck_q <= ~tck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tck = tck_q;

    // R2: a rising edge only follows a low half in which the step was armed
    a_r2_rise_armed: assert property (@(posedge clk) disable iff (rst)
        $rose(tck_q) |-> $past(en));

endmodule

// File: rtl/tap_step_seq.sv
module tap_step_seq
    import cfg_tap_pkg::*;
#(
    parameter int STARTUP_CYC = 12,
    parameter bit CFG_IR_MSB   = 1'b1,
    parameter bit START_IR_MSB = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic fall_ev,
    input  logic s_valid,
    input  logic s_data,
    input  logic s_last,
    output logic s_ready,
    output logic armed,
    output logic busy,
    output logic tms,
    output logic tdi,
    output logic done
);
    localparam logic [STEP_W-1:0] SC = STEP_W'(STARTUP_CYC);
    localparam logic [IR_LEN-1:0] CFG_IR   = {CFG_IR_MSB, CFG_IR_LOW};
    localparam logic [IR_LEN-1:0] START_IR = {START_IR_MSB, START_IR_LOW};
    localparam logic [STEP_W-1:0] IR_TOP   = STEP_W'(IR_LEN - 1);

    phase_e            phase_q;
    logic [STEP_W-1:0] idx_q;
    logic              armed_q;
    logic              last_q;
    pin_pair_t         pins_q;
    pin_pair_t         step;
    logic              need_load;
    logic              load_en;
    logic              seg_end;

    always_comb begin
        step = '{tms: 1'b1, tdi: 1'b0};
        case (phase_q)
            PH_RTI_A, PH_ENT_IR_A, PH_ENT_DR, PH_ENT_IR_B, PH_STARTUP:
                step.tms = 1'b0;
            PH_IR_CFG: begin
                step.tms = (idx_q == IR_TOP);
                step.tdi = ir_pick(CFG_IR, idx_q);
            end
            PH_IR_START: begin
                step.tms = (idx_q == IR_TOP);
                step.tdi = ir_pick(START_IR, idx_q);
            end
            PH_RST_B:
                step.tms = (idx_q < 16'd4);
            PH_DATA: begin
                step.tms = s_last;
                step.tdi = s_data;
            end
            default: ;
        endcase
    end

    always_comb begin
        busy      = (phase_q != PH_IDLE) && (phase_q != PH_DONE);
        need_load = busy && !armed_q;
        s_ready   = need_load && (phase_q == PH_DATA);
        load_en   = need_load && ((phase_q != PH_DATA) || s_valid);
        seg_end   = (phase_q == PH_DATA) ? last_q
                                         : (idx_q == phase_len(phase_q, SC) - 16'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            armed_q <= 1'b0;
            last_q  <= 1'b0;
            pins_q  <= '{tms: 1'b1, tdi: 1'b0};
        end else if (start && !busy) begin
            phase_q <= PH_RST_A;
            idx_q   <= '0;
            armed_q <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            if (load_en) begin
                pins_q  <= step;
                armed_q <= 1'b1;
                last_q  <= (phase_q == PH_DATA) && s_last;
            end
            if (fall_ev) begin
                armed_q <= 1'b0;
                if (seg_end) begin
                    phase_q <= next_phase(phase_q);
                    idx_q   <= '0;
                end else begin
                    idx_q <= idx_q + 16'd1;
                end
            end
        end
    end

    assign armed = armed_q;
    assign tms   = pins_q.tms;
    assign tdi   = pins_q.tdi;
    assign done  = (phase_q == PH_DONE);

    // R12: a start pulse during a run never re-enters the opening reset
    a_r12_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && phase_q != PH_RST_A) |=> (phase_q != PH_RST_A));

    // R11: a stream bit is taken only when no step is pending on the pins
    a_r11_take_unarmed: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> armed_q);

endmodule

// File: rtl/tap_cycle_tally.sv
module tap_cycle_tally #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else if (inc)     cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    // R10: the tally never moves without an increment strobe
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(inc) && !$past(clear)) |-> $stable(cnt_q));

endmodule

// File: rtl/cfg_tap_loader.sv
module cfg_tap_loader #(
    parameter int DIV_HALF     = 2,
    parameter int STARTUP_CYC  = 12,
    parameter bit CFG_IR_MSB   = 1'b1,
    parameter bit START_IR_MSB = 1'b1,
    parameter int CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             done,
    input  logic             s_valid,
    input  logic             s_data,
    input  logic             s_last,
    output logic             s_ready,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    output logic [CNT_W-1:0] tck_count
);
    logic armed;
    logic busy;
    logic rise_ev;
    logic fall_ev;

    tap_tck_div #(.HALF(DIV_HALF)) u_div (
        .clk     (clk),
        .rst     (rst),
        .en      (armed),
        .tck     (tck),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    tap_step_seq #(
        .STARTUP_CYC  (STARTUP_CYC),
        .CFG_IR_MSB   (CFG_IR_MSB),
        .START_IR_MSB (START_IR_MSB)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .fall_ev (fall_ev),
        .s_valid (s_valid),
        .s_data  (s_data),
        .s_last  (s_last),
        .s_ready (s_ready),
        .armed   (armed),
        .busy    (busy),
        .tms     (tms),
        .tdi     (tdi),
        .done    (done)
    );

    tap_cycle_tally #(.W(CNT_W)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .clear (start && !busy),
        .inc   (rise_ev),
        .count (tck_count)
    );

    // R2: pins hold steady through the high half of TCK
    a_r2_pins_stable_high: assert property (@(posedge clk) disable iff (rst)
        (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

    // R11: the stream is only ready while TCK is low
    a_r11_ready_tck_low: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> !tck);

    // R10: each TCK rising edge adds exactly one to the count
    a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
        $rose(tck) |-> (tck_count == $past(tck_count) + 1'b1));

    // R9: once finished, TCK is parked low with TMS high
    a_r9_parked: assert property (@(posedge clk) disable iff (rst)
        done |-> (!tck && tms));

endmodule

// File: tb/cfg_tap_loader_tb_top.sv
module cfg_tap_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int MAXSEQ     = 128;
    localparam logic [9:0] CFG_BITS   = 10'b1101000111;
    localparam logic [9:0] START_BITS = 10'b1001100111;

    typedef struct packed {
        logic [7:0]  n;
        logic [7:0]  gap;
        logic        poke;
        logic [63:0] data;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{n: 8'd1,  gap: 8'd0,  poke: 1'b0, data: 64'h1},
        '{n: 8'd8,  gap: 8'd0,  poke: 1'b0, data: 64'hA5},
        '{n: 8'd13, gap: 8'd3,  poke: 1'b1, data: 64'h1B2D},
        '{n: 8'd5,  gap: 8'd20, poke: 1'b0, data: 64'h0A},
        '{n: 8'd64, gap: 8'd1,  poke: 1'b0, data: 64'hF0E1_D2C3_B4A5_9687}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        done;
    logic        s_valid = 1'b0;
    logic        s_data = 1'b0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic        tck, tms, tdi;
    logic [15:0] tck_count;

    int checks = 0;
    int errors = 0;

    logic cap_tms [MAXSEQ];
    logic cap_tdi [MAXSEQ];
    logic exp_tms [MAXSEQ];
    logic exp_tdi [MAXSEQ];
    int   cap_n = 0;
    int   exp_n = 0;
    int   hi_len = 0, lo_len = 0;
    int   v_width = 0, v_pins = 0, v_stall = 0;
    logic p_tck = 1'b0, p_tms = 1'b1, p_tdi = 1'b0, p_rdy = 1'b0;
    logic [15:0] p_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_tap_loader dut_i (
        .clk(clk), .rst(rst), .start(start), .done(done),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .tck(tck), .tms(tms), .tdi(tdi), .tck_count(tck_count)
    );

    always @(posedge tck) begin
        if (cap_n < MAXSEQ) begin
            cap_tms[cap_n] = tms;
            cap_tdi[cap_n] = tdi;
        end
        cap_n = cap_n + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (tck && p_tck) begin
                hi_len = hi_len + 1;
                if (tms !== p_tms || tdi !== p_tdi) v_pins = v_pins + 1;
            end else if (tck && !p_tck) begin
                if (lo_len < DIV) v_width = v_width + 1;
                hi_len = 1;
            end else if (!tck && p_tck) begin
                if (hi_len != DIV) v_width = v_width + 1;
                lo_len = 1;
            end else begin
                lo_len = lo_len + 1;
            end
            if (s_ready && tck) v_stall = v_stall + 1;
            if (s_ready && p_rdy && tck_count != p_cnt) v_stall = v_stall + 1;
        end
        p_tck = tck; p_tms = tms; p_tdi = tdi; p_rdy = s_ready; p_cnt = tck_count;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic m, input logic d);
        exp_tms[exp_n] = m;
        exp_tdi[exp_n] = d;
        exp_n++;
    endtask

    task automatic push_n(input int k, input logic m);
        for (int i = 0; i < k; i++) push(m, 1'b0);
    endtask

    task automatic build(input int n, input logic [63:0] d);
        exp_n = 0;
        push_n(5, 1'b1); push_n(1, 1'b0); push_n(2, 1'b1); push_n(2, 1'b0);       // R3
        for (int i = 0; i < 10; i++) push(i == 9, CFG_BITS[i]);                   // R4
        push_n(2, 1'b1); push_n(2, 1'b0);                                         // R5
        for (int j = n - 1; j >= 0; j--) push(j == 0, d[j]);                      // R6
        push_n(1, 1'b1);
        push_n(4, 1'b1); push_n(1, 1'b0); push_n(2, 1'b1); push_n(2, 1'b0);       // R7
        for (int i = 0; i < 10; i++) push(i == 9, START_BITS[i]);                 // R8
        push_n(1, 1'b1);
        push_n(12, 1'b0); push_n(3, 1'b1);                                        // R9
    endtask

    function automatic string tag_of(input int i, input int n);
        if (i < 10)      return "R3";
        if (i < 20)      return "R4";
        if (i < 24)      return "R5";
        if (i < 25 + n)  return "R6";
        if (i < 34 + n)  return "R7";
        if (i < 45 + n)  return "R8";
        return "R9";
    endfunction

    task automatic run_vec(input vec_t v);
        int n;
        n = int'(v.n);
        build(n, v.data);
        v_width = 0; v_pins = 0; v_stall = 0;
        @(negedge clk);
        cap_n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R12", "done low after start", done, 0);
        for (int j = n - 1; j >= 0; j--) begin
            s_valid = 1'b1;
            s_data  = v.data[j];
            s_last  = (j == 0);
            while (!s_ready) @(negedge clk);
            @(negedge clk);
            s_valid = 1'b0;
            s_data  = 1'b0;
            s_last  = 1'b0;
            if (v.poke && j == n - 1) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            for (int g = 0; g < int'(v.gap); g++) @(negedge clk);
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        check(done == 1'b1 && tck == 1'b0 && tms == 1'b1, "R9", "parked after run",
              {done, tck, tms}, 3'b101);
        check(int'(tck_count) == 60 + n, "R10", "cycle count", tck_count, 60 + n);
        check(cap_n == 60 + n, "R10", "rising edges seen", cap_n, 60 + n);
        if (cap_n == exp_n) begin
            for (int i = 0; i < exp_n; i++) begin
                check(cap_tms[i] === exp_tms[i], tag_of(i, n), $sformatf("tms @%0d", i),
                      cap_tms[i], exp_tms[i]);
                check(cap_tdi[i] === exp_tdi[i], tag_of(i, n), $sformatf("tdi @%0d", i),
                      cap_tdi[i], exp_tdi[i]);
            end
        end
        check(v_width == 0, "R2", "tck half widths", v_width, 0);
        check(v_pins == 0, "R2", "pins stable while tck high", v_pins, 0);
        check(v_stall == 0, "R11", "stall holds tck and count", v_stall, 0);
        if (v.poke)
            check(int'(tck_count) == 60 + n, "R12", "start mid-run ignored", tck_count, 60 + n);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not end", 0, 1);
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check(tck == 1'b0, "R1", "tck after reset", tck, 0);
        check(tms == 1'b1, "R1", "tms after reset", tms, 1);
        check(tdi == 1'b0, "R1", "tdi after reset", tdi, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(s_ready == 1'b0, "R1", "s_ready after reset", s_ready, 0);
        check(tck_count == 16'd0, "R1", "count after reset", tck_count, 0);
        // R11: offering a bit while idle is not taken and does not clock
        s_valid = 1'b1; s_data = 1'b1; s_last = 1'b1;
        repeat (6) @(negedge clk);
        check(s_ready == 1'b0 && tck == 1'b0 && tck_count == 16'd0, "R11",
              "idle ignores stream", {s_ready, tck}, 0);
        s_valid = 1'b0; s_data = 1'b0; s_last = 1'b0;

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R12: a fresh start after done clears the count at once
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0 && tck_count == 16'd0, "R12", "restart clears count",
              tck_count, 0);
        finish_up();
    end

endmodule